// File: doc/BRIEF.md
# Configuration Register Access Width Checker

This block guards one device's 4 KB configuration register file. Requests come from two paths: the legacy port-based configuration path and the memory-mapped extended path. Each request carries a byte offset, a size code and a flag that marks an access to the configuration address pointer register. The block checks the size, the alignment and the path against the rules for the addressed offset. A legal access goes to the register file as a dword address with little-endian byte enables and lane-shifted write data. A rejected access raises an error pulse and never reaches the file.

Reads return their data on a response port one cycle after the register file is addressed. The data is shifted down to bit 0 and masked to the access size. A rejected read returns all ones. The contents of the register file are outside this block, and so is the decoding of bus, device and function.

Top module: `cfg_width_guard`

## Requirements
- R1: At offsets 0 to 255, byte (size code 0), word (size code 1) and dword (size code 2) accesses are accepted on either path (path 0 = legacy port, path 1 = memory-mapped).
- R2: An access flagged as targeting the address pointer register is accepted only as a dword. It is forwarded with `ptr_sel` high and all four byte enables set. Byte and word pointer accesses are rejected.
- R3: A byte or word access sets only the byte enables it covers, starting at lane `offset[1:0]`. Its write data is placed at bit `8*offset[1:0]`, so the other bytes of the dword are left unchanged.
- R4: At offsets 256 to 4095, only a memory-mapped dword access is accepted. Any access there from the legacy port path, and any smaller access, is rejected.
- R5: A rejected read returns `rsp_rdata` of all ones.
- R6: A word access with `offset[0]` set, a dword access with `offset[1:0]` not zero, and any access with size code 3 are rejected.
- R7: A rejected access pulses `err` for exactly one cycle and raises neither `rf_req` nor `rf_we`.
- R8: A legal read returns the addressed bytes in little-endian order. The byte at the lowest offset is placed in bits 7:0, and the bits above the access size are zero.
- R9: `rf_*` and `err` change one cycle after the request is sampled. `rsp_valid` and `rsp_rdata` follow one cycle later, and only for reads. With no request, all strobes stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_path | input | 1 | 0 legacy port path, 1 memory-mapped path |
| req_ptr | input | 1 | Access targets the address pointer register |
| req_write | input | 1 | 1 write, 0 read |
| req_size | input | 2 | 0 byte, 1 word, 2 dword, 3 invalid |
| req_offset | input | 12 | Byte offset in the device space |
| req_wdata | input | 32 | Write data, right-justified |
| rf_rdata | input | 32 | Dword read from the register file at `rf_dw_addr` |
| rf_req | output | 1 | Legal access forwarded |
| rf_we | output | 1 | Write strobe |
| rf_ptr_sel | output | 1 | Forwarded access is to the pointer register |
| rf_dw_addr | output | 10 | Dword address |
| rf_be | output | 4 | Byte enables |
| rf_wdata | output | 32 | Lane-aligned write data |
| err | output | 1 | Rejection pulse |
| rsp_valid | output | 1 | Read response present |
| rsp_rdata | output | 32 | Read data, right-justified |

## Verification
The register file side (`rf_req`, `rf_we`, `rf_be`, `rf_wdata`, `rf_dw_addr`) and `err` are due in the first cycle after the request edge. Read responses are due one cycle later. For each access the bench drives inputs on a falling edge and samples the register file side and `err` at the next falling edge. It samples the response, and checks that `err` and `rf_req` have dropped, at the falling edge after that. A behavioural byte-array model supplies expected enables, data and read results, so every value is compared in the cycle it is due.

// File: rtl/cfg_guard_pkg.sv
package cfg_guard_pkg;
  localparam int CFG_DW = 32;
  localparam int LANES  = CFG_DW / 8;
  localparam int LANE_W = $clog2(LANES);

  typedef enum logic [1:0] {SZ_BYTE = 2'd0, SZ_WORD = 2'd1, SZ_DWORD = 2'd2, SZ_BAD = 2'd3} acc_size_e;

  // alignment rule for a size at a lane position
  function automatic logic size_aligned(acc_size_e sz, logic [LANE_W-1:0] lane);
    case (sz)
      SZ_BYTE:  return 1'b1;
      SZ_WORD:  return ~lane[0];
      SZ_DWORD: return (lane == '0);
      default:  return 1'b0;
    endcase
  endfunction

  // byte enables covered by an access
  function automatic logic [LANES-1:0] lane_mask(acc_size_e sz, logic [LANE_W-1:0] lane);
    case (sz)
      SZ_BYTE: return LANES'(1) << lane;
      SZ_WORD: return LANES'(3) << lane;
      default: return '1;
    endcase
  endfunction

  // bits kept in a right-justified result
  function automatic logic [CFG_DW-1:0] width_mask(acc_size_e sz);
    case (sz)
      SZ_BYTE: return CFG_DW'(32'h0000_00FF);
      SZ_WORD: return CFG_DW'(32'h0000_FFFF);
      default: return '1;
    endcase
  endfunction
endpackage

// File: rtl/cfg_rule_check.sv
module cfg_rule_check
  import cfg_guard_pkg::*;
#(
  parameter int OFS_W    = 12,
  parameter int LOW_SPAN = 256
) (
  input  logic             path_mmio,
  input  logic             is_ptr,
  input  acc_size_e        size,
  input  logic [OFS_W-1:0] offset,
  output logic             in_ext,
  output logic             align_ok,
  output logic             path_ok,
  output logic             legal
);
  always_comb begin
    in_ext   = (int'(offset) >= LOW_SPAN);
    align_ok = size_aligned(size, offset[LANE_W-1:0]);
    if (is_ptr)
      path_ok = (size == SZ_DWORD);
    else if (in_ext)
      path_ok = path_mmio && (size == SZ_DWORD);
    else
      path_ok = 1'b1;
    legal = align_ok && path_ok;
  end
endmodule

// File: rtl/cfg_lane_align.sv
module cfg_lane_align
  import cfg_guard_pkg::*;
(
  input  acc_size_e          size,
  input  logic [LANE_W-1:0]  lane,
  input  logic [CFG_DW-1:0]  wdata_in,
  output logic [LANES-1:0]   be,
  output logic [CFG_DW-1:0]  wdata_out
);
  always_comb begin
    be        = lane_mask(size, lane);
    wdata_out = (wdata_in & width_mask(size)) << (8 * lane);
  end
endmodule

// File: rtl/cfg_read_return.sv
module cfg_read_return
  import cfg_guard_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_good,
  input  logic              rd_bad,
  input  acc_size_e         size,
  input  logic [LANE_W-1:0] lane,
  input  logic [CFG_DW-1:0] rf_rdata,
  output logic              rsp_valid,
  output logic [CFG_DW-1:0] rsp_rdata
);
  logic [CFG_DW-1:0] shifted;
  assign shifted = (rf_rdata >> (8 * lane)) & width_mask(size);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= rd_good || rd_bad;
      if (rd_bad)       rsp_rdata <= '1;
      else if (rd_good) rsp_rdata <= shifted;
    end
  end
endmodule

// File: rtl/cfg_width_guard.sv
module cfg_width_guard
  import cfg_guard_pkg::*;
#(
  parameter int OFS_W    = 12,
  parameter int LOW_SPAN = 256,
  localparam int ADDR_W  = OFS_W - LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_path,
  input  logic              req_ptr,
  input  logic              req_write,
  input  logic [1:0]        req_size,
  input  logic [OFS_W-1:0]  req_offset,
  input  logic [CFG_DW-1:0] req_wdata,
  input  logic [CFG_DW-1:0] rf_rdata,
  output logic              rf_req,
  output logic              rf_we,
  output logic              rf_ptr_sel,
  output logic [ADDR_W-1:0] rf_dw_addr,
  output logic [LANES-1:0]  rf_be,
  output logic [CFG_DW-1:0] rf_wdata,
  output logic              err,
  output logic              rsp_valid,
  output logic [CFG_DW-1:0] rsp_rdata
);
  acc_size_e         size_in;
  logic              in_ext, align_ok, path_ok, legal;
  logic [LANES-1:0]  be_next;
  logic [CFG_DW-1:0] wd_next;
  logic              accept, reject;

  // held request attributes for the read return stage
  acc_size_e         s1_size;
  logic [LANE_W-1:0] s1_lane;
  logic              s1_rd_good, s1_rd_bad;

  assign size_in = acc_size_e'(req_size);
  assign accept  = req_valid && legal;
  assign reject  = req_valid && !legal;

  cfg_rule_check #(.OFS_W(OFS_W), .LOW_SPAN(LOW_SPAN)) u_rules (
    .path_mmio (req_path),
    .is_ptr    (req_ptr),
    .size      (size_in),
    .offset    (req_offset),
    .in_ext    (in_ext),
    .align_ok  (align_ok),
    .path_ok   (path_ok),
    .legal     (legal)
  );

  cfg_lane_align u_lanes (
    .size      (size_in),
    .lane      (req_offset[LANE_W-1:0]),
    .wdata_in  (req_wdata),
    .be        (be_next),
    .wdata_out (wd_next)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rf_req     <= 1'b0;
      rf_we      <= 1'b0;
      rf_ptr_sel <= 1'b0;
      rf_dw_addr <= '0;
      rf_be      <= '0;
      rf_wdata   <= '0;
      err        <= 1'b0;
      s1_size    <= SZ_BYTE;
      s1_lane    <= '0;
      s1_rd_good <= 1'b0;
      s1_rd_bad  <= 1'b0;
    end else begin
      rf_req     <= accept;
      rf_we      <= accept && req_write;
      err        <= reject;
      s1_rd_good <= accept && !req_write;
      s1_rd_bad  <= reject && !req_write;
      if (req_valid) begin
        rf_ptr_sel <= req_ptr;
        rf_dw_addr <= req_offset[OFS_W-1:LANE_W];
        rf_be      <= accept ? be_next : '0;
        rf_wdata   <= wd_next;
        s1_size    <= size_in;
        s1_lane    <= req_offset[LANE_W-1:0];
      end
    end
  end

  cfg_read_return u_ret (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_good   (s1_rd_good),
    .rd_bad    (s1_rd_bad),
    .size      (s1_size),
    .lane      (s1_lane),
    .rf_rdata  (rf_rdata),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata)
  );
endmodule

// File: rtl/cfg_width_guard_checker.sv
module cfg_width_guard_checker
  import cfg_guard_pkg::*;
#(
  parameter int OFS_W    = 12,
  parameter int LOW_SPAN = 256,
  localparam int ADDR_W  = OFS_W - LANE_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_path,
  input logic              rf_req,
  input logic              rf_we,
  input logic              rf_ptr_sel,
  input logic [ADDR_W-1:0] rf_dw_addr,
  input logic [LANES-1:0]  rf_be,
  input logic              err,
  input logic              rsp_valid,
  input logic [CFG_DW-1:0] rsp_rdata
);
  localparam int EXT_DW = LOW_SPAN / LANES;

  p_err_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (!rf_req && !rf_we));
  p_err_after_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> $past(req_valid));
  p_ext_mmio_dword_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_req && !rf_ptr_sel && int'(rf_dw_addr) >= EXT_DW) |-> (rf_be == '1 && $past(req_path)));
  p_ptr_dword_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_req && rf_ptr_sel) |-> rf_be == '1);
  p_be_shape_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rf_req |-> ($countones(rf_be) != 0 && $countones(rf_be) != 3));
  p_bad_read_ones_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && $past(err)) |-> (&rsp_rdata));
  p_rsp_follows_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(err || (rf_req && !rf_we)));
endmodule

bind cfg_width_guard cfg_width_guard_checker #(.OFS_W(OFS_W), .LOW_SPAN(LOW_SPAN)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_path   (req_path),
  .rf_req     (rf_req),
  .rf_we      (rf_we),
  .rf_ptr_sel (rf_ptr_sel),
  .rf_dw_addr (rf_dw_addr),
  .rf_be      (rf_be),
  .err        (err),
  .rsp_valid  (rsp_valid),
  .rsp_rdata  (rsp_rdata)
);

// File: tb/test_cfg_width_guard.sv
module test_cfg_width_guard;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_path = 1'b0, req_ptr = 1'b0, req_write = 1'b0;
  logic [1:0]  req_size = 2'd0;
  logic [11:0] req_offset = '0;
  logic [31:0] req_wdata = '0;
  logic [31:0] rf_rdata;
  logic        rf_req, rf_we, rf_ptr_sel, err, rsp_valid;
  logic [9:0]  rf_dw_addr;
  logic [3:0]  rf_be;
  logic [31:0] rf_wdata, rsp_rdata;

  int checks = 0;
  int errors = 0;

  // register file stand-in driven by the guard's outputs
  logic [31:0] mem [0:1023];
  logic [31:0] ptr_mem;
  // behavioural expectation model
  byte unsigned shadow [0:4095];
  logic [31:0] ptr_shadow;

  always #5 clk = ~clk;

  assign rf_rdata = rf_ptr_sel ? ptr_mem : mem[rf_dw_addr];

  always @(posedge clk) begin
    if (rf_we) begin
      for (int k = 0; k < 4; k++)
        if (rf_be[k]) begin
          if (rf_ptr_sel) ptr_mem[8*k +: 8] <= rf_wdata[8*k +: 8];
          else mem[rf_dw_addr][8*k +: 8] <= rf_wdata[8*k +: 8];
        end
    end
  end

  cfg_width_guard i_cfg_width_guard (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_path(req_path),
    .req_ptr(req_ptr), .req_write(req_write), .req_size(req_size),
    .req_offset(req_offset), .req_wdata(req_wdata), .rf_rdata(rf_rdata),
    .rf_req(rf_req), .rf_we(rf_we), .rf_ptr_sel(rf_ptr_sel),
    .rf_dw_addr(rf_dw_addr), .rf_be(rf_be), .rf_wdata(rf_wdata),
    .err(err), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic access(input bit mmio, input bit ptr, input bit wr, input int sz,
                        input int off, input logic [31:0] data, input string req);
    int bytes;
    bit ok;
    logic [3:0]  be;
    logic [31:0] expr, lane_data;
    bytes = (sz < 3) ? (1 << sz) : 0;
    ok = (sz < 3) && (off % bytes == 0);
    if (ptr) ok = ok && (bytes == 4);
    else if (off >= 256) ok = ok && mmio && (bytes == 4);
    be = 4'b0;
    lane_data = 32'h0;
    for (int k = 0; k < bytes; k++) begin
      be[(off % 4) + k] = 1'b1;
      lane_data[8*((off % 4) + k) +: 8] = data[8*k +: 8];
    end
    expr = 32'hFFFF_FFFF;
    if (ok) begin
      expr = 32'h0;
      if (ptr) expr = ptr_shadow;
      else for (int k = 0; k < bytes; k++) expr[8*k +: 8] = shadow[off + k];
    end
    @(negedge clk);
    req_valid = 1'b1; req_path = mmio; req_ptr = ptr; req_write = wr;
    req_size = 2'(sz); req_offset = 12'(off); req_wdata = data;
    @(negedge clk);
    req_valid = 1'b0;
    check(err == !ok, {req, " err"}, 32'(err), 32'(!ok));
    check(rf_req == ok && rf_we == (ok && wr), {req, " strobes"}, {30'd0, rf_req, rf_we}, {30'd0, ok, ok && wr});
    if (ok) begin
      check(rf_be == be, {req, " byte enables"}, 32'(rf_be), 32'(be));
      check(rf_dw_addr == 10'(off / 4) && rf_ptr_sel == ptr, {req, " address"}, 32'(rf_dw_addr), 32'(off / 4));
      if (wr)
        for (int k = 0; k < 4; k++)
          if (be[k]) check(rf_wdata[8*k +: 8] == lane_data[8*k +: 8], {req, " write lane"}, rf_wdata, lane_data);
    end
    @(negedge clk);
    check(err == 1'b0 && rf_req == 1'b0, {req, " one-cycle pulse R7"}, {30'd0, err, rf_req}, 32'd0);
    check(rsp_valid == !wr, {req, " response valid R9"}, 32'(rsp_valid), 32'(!wr));
    if (!wr) check(rsp_rdata == expr, {req, " read data"}, rsp_rdata, expr);
    if (ok && wr) begin
      if (ptr) ptr_shadow = data;
      else for (int k = 0; k < bytes; k++) shadow[off + k] = data[8*k +: 8];
    end
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog R9 actual=%h expected=%h", 32'd1, 32'd0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int a = 0; a < 4096; a++) shadow[a] = 8'((a * 7 + 3) & 255);
    for (int d = 0; d < 1024; d++)
      mem[d] = {shadow[4*d+3], shadow[4*d+2], shadow[4*d+1], shadow[4*d]};
    ptr_mem = 32'h8000_1234;
    ptr_shadow = 32'h8000_1234;
    repeat (3) @(negedge clk);
    check(rf_req == 0 && err == 0 && rsp_valid == 0 && rf_we == 0, "reset R9",
          {28'd0, rf_req, err, rsp_valid, rf_we}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(rf_req == 0 && err == 0 && rsp_valid == 0, "idle R9", {29'd0, rf_req, err, rsp_valid}, 32'd0);

    // R1 R8 low space reads on both paths, little-endian
    access(0, 0, 0, 2, 16'h10, 0, "R1 R8 port dword read");
    access(1, 0, 0, 0, 16'h13, 0, "R1 R8 mmio byte read lane3");
    access(0, 0, 0, 1, 16'h22, 0, "R1 R8 port word read lane2");
    // R3 partial writes leave neighbours intact
    access(0, 0, 1, 0, 16'h41, 32'hFFFF_FFA5, "R3 byte write lane1");
    access(1, 0, 1, 1, 16'h46, 32'h0000_BEEF, "R3 word write lane2");
    access(0, 0, 0, 2, 16'h40, 0, "R3 R8 dword readback");
    access(0, 0, 0, 2, 16'h44, 0, "R3 R8 dword readback 2");
    access(1, 0, 1, 2, 16'hFC, 32'h1122_3344, "R1 dword write top of low space");
    access(0, 0, 0, 1, 16'hFE, 0, "R1 R8 word read top");
    // R2 pointer register
    access(0, 1, 1, 2, 0, 32'h8000_0A48, "R2 pointer dword write");
    access(0, 1, 0, 2, 0, 0, "R2 pointer dword read");
    access(0, 1, 1, 0, 0, 32'h0000_00EE, "R2 R7 pointer byte write rejected");
    access(0, 1, 0, 1, 0, 0, "R2 R5 pointer word read rejected");
    access(0, 1, 0, 2, 0, 0, "R2 pointer unchanged");
    // R4 extended space
    access(1, 0, 1, 2, 16'h100, 32'hCAFE_F00D, "R4 mmio dword write ext");
    access(1, 0, 0, 2, 16'h100, 0, "R4 mmio dword read ext");
    access(0, 0, 1, 2, 16'h100, 32'h0, "R4 R7 port write ext rejected");
    access(0, 0, 0, 2, 16'h100, 0, "R4 R5 port read ext rejected");
    access(1, 0, 0, 0, 16'hFFF, 0, "R4 R5 mmio byte ext rejected");
    access(1, 0, 1, 1, 16'h200, 32'h1, "R4 mmio word write ext rejected");
    access(1, 0, 0, 2, 16'h200, 0, "R4 ext unchanged");
    access(1, 0, 0, 2, 16'h100, 0, "R4 ext unchanged after port write");
    // R6 misaligned and invalid size
    access(0, 0, 1, 1, 16'h31, 32'h0000_5555, "R6 R7 word misaligned write");
    access(0, 0, 0, 2, 16'h32, 0, "R6 R5 dword misaligned read");
    access(1, 0, 0, 3, 16'h30, 0, "R6 R5 size code 3 read");
    access(0, 0, 0, 2, 16'h30, 0, "R6 dword unchanged");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule